// File: doc/BRIEF.md
# Wormhole Port Allocator

This block chooses the output port for each packet waiting at an input of a multi-port packet switch, and it keeps that port reserved until the packet's end marker has passed. The leading header byte of the waiting packet indexes a routing table, which software can write while the switch runs. Each table entry is a set of interchangeable outputs, so a packet can leave through any working member of its set.

Every cycle, each waiting input proposes the lowest-numbered member of its set whose link is up and which no other packet holds. One round-robin arbiter per output settles contention between inputs that propose the same output. A header whose entry is empty, or whose set has no link up when the header is read, is flagged and discarded up to its end marker. Link signalling, buffering and the crossbar datapath sit outside this block.

Top module: `wh_port_alloc`

## Requirements
- R1: After reset, `gnt_o`, `drop_o` and `out_busy_o` are all zero, and every table entry is empty (all bits zero).
- R2: Input i takes its header `hdr_i[i*8 +: 8]` at a rising edge where it is idle and `req_i[i]` is high. It looks up the table entry indexed by the full header byte, where bit k of the entry means that output k is in the set. The grant can appear at the second rising edge at the earliest. The port granted, `gnt_port_o[i*3 +: 3]`, is always a member of the set and has its link up.
- R3: A waiting input is given the lowest-numbered member of its set that has its link up and is not held.
- R4: Once `gnt_o[i]` rises, it stays high and the port in `gnt_port_o` stays unchanged until a cycle in which `eop_i[i]` is high. Both the grant and that output's `out_busy_o` bit drop at the following edge.
- R5: No output is held by two inputs at the same time.
- R6: When several inputs wait for the same output, that output goes to the first requester found at or after its pointer, searching upward with wraparound. The pointer moves to the input just after the one granted, and it moves only when a grant is made.
- R7: An output in the set whose `link_up_i` bit is low is skipped, and the packet goes to another member of the same set.
- R8: A header whose table entry is empty raises `drop_o[i]` and gives no grant. `drop_o[i]` stays high until `eop_i[i]` and then clears.
- R9: A header whose set has no member with its link up at lookup time is discarded in the same way as in R8.
- R10: A table write (`tbl_we_i`, `tbl_addr_i`, `tbl_mask_i`) affects only headers taken at a later edge. A header taken at the same edge as the write uses the old entry.
- R11: While an input waits, its choice is re-evaluated every cycle. A member that comes up or becomes free later is granted without a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Routing table write strobe |
| tbl_addr_i | input | 8 | Table entry to write (header value) |
| tbl_mask_i | input | 8 | Output set to store; bit k selects output k |
| link_up_i | input | 8 | Per-output link health, 1 = usable |
| req_i | input | 8 | Per-input flag: a packet header is waiting |
| hdr_i | input | 64 | Header byte of each input, input i at bits [i*8 +: 8] |
| eop_i | input | 8 | Per-input end-of-packet marker passing this cycle |
| gnt_o | output | 8 | Per-input flag: an output is held for this packet |
| gnt_port_o | output | 24 | Held output of each input, input i at bits [i*3 +: 3] |
| drop_o | output | 8 | Per-input flag: packet flagged as unroutable and being discarded |
| out_busy_o | output | 8 | Per-output flag: held by some input |

## Verification
The bench aims at three failures. The first is a packet that gets the wrong member of its set: a design that ignores link health or which outputs are held would send it to a dead or occupied output. The second is a pointer that does not rotate: after one output is released, a fixed-priority arbiter would hand it to the lower-numbered waiter instead of the one just past the last winner. The third is a lookup whose timing is wrong or whose failure is not caught: a table write that reaches a header in the same cycle, an empty entry that is granted, or a set with no link up that is not discarded. It also holds an input waiting on a dead and a busy member, then brings a member up to check that the input is granted.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_DROP = 2'd3
  } in_state_e;
endpackage

// File: rtl/alloc_route_table.sv
module alloc_route_table #(
  parameter int N_PORTS = 8,
  parameter int HDR_W   = 8,
  localparam int DEPTH  = 1 << HDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [HDR_W-1:0]           waddr_i,
  input  logic [N_PORTS-1:0]         wdata_i,
  input  logic [N_PORTS*HDR_W-1:0]   raddr_i,
  output logic [N_PORTS*N_PORTS-1:0] rdata_o
);
  logic [N_PORTS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // one read port per input; reads see the table before this edge's write
  for (genvar g = 0; g < N_PORTS; g++) begin : g_rd
    assign rdata_o[g*N_PORTS +: N_PORTS] = mem_q[raddr_i[g*HDR_W +: HDR_W]];
  end
endmodule

// File: rtl/alloc_rr_arb.sv
module alloc_rr_arb #(
  parameter int N   = 8,
  localparam int PW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;
  logic          found;
  int            idx;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (found) ptr_q <= (int'(win) == N-1) ? '0 : win + 1'b1;
  end

  p_gnt_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_gnt_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_work_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/alloc_in_ctrl.sv
module alloc_in_ctrl
  import alloc_pkg::*;
#(
  parameter int N   = 8,
  localparam int PW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          eop_i,
  input  logic [N-1:0]  lk_mask_i,
  input  logic [N-1:0]  link_up_i,
  input  logic [N-1:0]  out_busy_i,
  input  logic          win_i,
  output logic [PW-1:0] cand_o,
  output logic          cand_vld_o,
  output logic          gnt_o,
  output logic [PW-1:0] port_o,
  output logic          drop_o
);
  in_state_e     st_q;
  logic [N-1:0]  mask_q;
  logic [PW-1:0] port_q;
  logic [N-1:0]  usable;

  // lowest idle, healthy member of the set
  always_comb begin
    usable = mask_q & link_up_i & ~out_busy_i;
    cand_o = '0;
    for (int k = N-1; k >= 0; k--) if (usable[k]) cand_o = PW'(k);
    cand_vld_o = (st_q == ST_WAIT) && (|usable);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      port_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          mask_q <= lk_mask_i;
          st_q   <= ((lk_mask_i & link_up_i) == '0) ? ST_DROP : ST_WAIT;
        end
        ST_WAIT: if (win_i) begin
          port_q <= cand_o;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (eop_i) st_q <= ST_IDLE;
        ST_DROP: if (eop_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_o  = (st_q == ST_HOLD);
  assign drop_o = (st_q == ST_DROP);
  assign port_o = port_q;

  p_member_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i |-> (cand_vld_o && mask_q[cand_o] && link_up_i[cand_o] && !out_busy_i[cand_o]));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !eop_i) |=> (gnt_o && $stable(port_o)));
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && eop_i) |=> !gnt_o);
  p_drop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !eop_i) |=> (drop_o && !gnt_o));
endmodule

// File: rtl/wh_port_alloc.sv
module wh_port_alloc #(
  parameter int N_PORTS = 8,
  parameter int HDR_W   = 8,
  localparam int PW     = $clog2(N_PORTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tbl_we_i,
  input  logic [HDR_W-1:0]         tbl_addr_i,
  input  logic [N_PORTS-1:0]       tbl_mask_i,
  input  logic [N_PORTS-1:0]       link_up_i,
  input  logic [N_PORTS-1:0]       req_i,
  input  logic [N_PORTS*HDR_W-1:0] hdr_i,
  input  logic [N_PORTS-1:0]       eop_i,
  output logic [N_PORTS-1:0]       gnt_o,
  output logic [N_PORTS*PW-1:0]    gnt_port_o,
  output logic [N_PORTS-1:0]       drop_o,
  output logic [N_PORTS-1:0]       out_busy_o
);
  logic [N_PORTS*N_PORTS-1:0] lk_mask;
  logic [PW-1:0]              cand     [N_PORTS];
  logic [N_PORTS-1:0]         cand_vld;
  logic [PW-1:0]              port     [N_PORTS];
  logic [N_PORTS-1:0]         arb_req  [N_PORTS]; // [output][input]
  logic [N_PORTS-1:0]         arb_gnt  [N_PORTS];
  logic [N_PORTS-1:0]         owner    [N_PORTS];
  logic [N_PORTS-1:0]         win;

  alloc_route_table #(.N_PORTS(N_PORTS), .HDR_W(HDR_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_mask_i),
    .raddr_i (hdr_i),
    .rdata_o (lk_mask)
  );

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    for (genvar i = 0; i < N_PORTS; i++) begin : g_map
      assign arb_req[o][i] = cand_vld[i] && (cand[i] == PW'(o));
      assign owner[o][i]   = gnt_o[i] && (port[i] == PW'(o));
    end
    assign out_busy_o[o] = |owner[o];

    alloc_rr_arb #(.N(N_PORTS)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (arb_req[o]),
      .gnt_o  (arb_gnt[o])
    );

    p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owner[o]));
  end

  always_comb begin
    win = '0;
    for (int o = 0; o < N_PORTS; o++) win = win | arb_gnt[o];
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    alloc_in_ctrl #(.N(N_PORTS)) u_in (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i[i]),
      .eop_i      (eop_i[i]),
      .lk_mask_i  (lk_mask[i*N_PORTS +: N_PORTS]),
      .link_up_i  (link_up_i),
      .out_busy_i (out_busy_o),
      .win_i      (win[i]),
      .cand_o     (cand[i]),
      .cand_vld_o (cand_vld[i]),
      .gnt_o      (gnt_o[i]),
      .port_o     (port[i]),
      .drop_o     (drop_o[i])
    );
    assign gnt_port_o[i*PW +: PW] = port[i];

    p_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(gnt_o[i]) |-> $past(eop_i[i]));
  end
endmodule

// File: tb/wh_port_alloc_tb_top.sv
module wh_port_alloc_tb_top;
  localparam int N  = 8;
  localparam int HW = 8;
  localparam int PW = 3;

  typedef struct { int inp; int port; bit drop; } evt_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_we = 1'b0;
  logic [HW-1:0] tbl_addr = '0;
  logic [N-1:0]  tbl_mask = '0;
  logic [N-1:0]  link_up = '1;
  logic [N-1:0]  req = '0;
  logic [N*HW-1:0] hdr = '0;
  logic [N-1:0]  eop = '0;
  logic [N-1:0]  gnt_o;
  logic [N*PW-1:0] gnt_port_o;
  logic [N-1:0]  drop_o;
  logic [N-1:0]  out_busy_o;

  int checks = 0;
  int fails  = 0;
  evt_t exp_q[$];
  logic [N-1:0] prev_g = '0;
  logic [N-1:0] prev_d = '0;

  always #5 clk = ~clk;

  wh_port_alloc #(.N_PORTS(N), .HDR_W(HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_mask_i(tbl_mask), .link_up_i(link_up), .req_i(req), .hdr_i(hdr),
    .eop_i(eop), .gnt_o(gnt_o), .gnt_port_o(gnt_port_o), .drop_o(drop_o),
    .out_busy_o(out_busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input int i, input int p, input bit d);
    evt_t e;
    e.inp = i; e.port = p; e.drop = d;
    exp_q.push_back(e);
  endtask

  task automatic tbl_wr(input int a, input logic [N-1:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = HW'(a); tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic open_pkt(input int i, input int h);
    req[i] = 1'b1;
    hdr[i*HW +: HW] = HW'(h);
  endtask

  task automatic wait_evt(input int i);
    do @(negedge clk); while (!(gnt_o[i] || drop_o[i]));
    req[i] = 1'b0;
  endtask

  task automatic close_pkt(input int i);
    @(negedge clk);
    eop[i] = 1'b1;
    @(negedge clk);
    eop[i] = 1'b0;
  endtask

  // scoreboard monitor: every new grant or drop is matched against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if ((gnt_o[i] && !prev_g[i]) || (drop_o[i] && !prev_d[i])) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected event input", i, -1);
          end else begin
            evt_t e;
            e = exp_q.pop_front();
            chk(e.inp == i, "R2 event input", i, e.inp);
            chk(drop_o[i] == e.drop, "R8 drop flag", int'(drop_o[i]), int'(e.drop));
            if (!e.drop)
              chk(int'(gnt_port_o[i*PW +: PW]) == e.port, "R3 granted port",
                  int'(gnt_port_o[i*PW +: PW]), e.port);
          end
        end
      end
      prev_g <= gnt_o;
      prev_d <= drop_o;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_o == '0, "R1 grants at reset", int'(gnt_o), 0);
    chk(drop_o == '0, "R1 drops at reset", int'(drop_o), 0);
    chk(out_busy_o == '0, "R1 busy at reset", int'(out_busy_o), 0);

    tbl_wr(8'h10, 8'b0000_0110);
    tbl_wr(8'h20, 8'b0001_1000);
    tbl_wr(8'h40, 8'b1100_0000);
    tbl_wr(8'h50, 8'b0010_0000);
    tbl_wr(8'h70, 8'b1000_0000);

    // R2/R3/R4: lowest member first, second requester gets next free member
    push(0, 1, 0);
    open_pkt(0, 8'h10);
    wait_evt(0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(gnt_o[0] && gnt_port_o[0 +: PW] == 3'd1, "R4 grant held",
          int'(gnt_port_o[0 +: PW]), 1);
    end
    chk(out_busy_o[1], "R4 output busy", int'(out_busy_o[1]), 1);
    push(1, 2, 0);
    open_pkt(1, 8'h10);
    wait_evt(1);
    close_pkt(0);
    chk(!gnt_o[0] && !out_busy_o[1], "R4 release after eop",
        int'(gnt_o[0]) + int'(out_busy_o[1]), 0);
    close_pkt(1);

    // R7: dead member skipped
    link_up[1] = 1'b0;
    push(0, 2, 0);
    open_pkt(0, 8'h10);
    wait_evt(0);
    close_pkt(0);
    link_up = '1;

    // R9: no member of the set up
    link_up[3] = 1'b0; link_up[4] = 1'b0;
    push(2, 0, 1);
    open_pkt(2, 8'h20);
    wait_evt(2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(drop_o[2] && !gnt_o[2] && out_busy_o == '0, "R9 discard held",
          int'(drop_o[2]), 1);
    end
    close_pkt(2);
    chk(!drop_o[2], "R8 drop clears at eop", int'(drop_o[2]), 0);
    link_up = '1;

    // R8: empty entry
    push(4, 0, 1);
    open_pkt(4, 8'h30);
    wait_evt(4);
    close_pkt(4);

    // R6: pointer moves past input 6, so 7 beats 2 on release
    push(6, 5, 0);
    open_pkt(6, 8'h50);
    wait_evt(6);
    push(7, 5, 0);
    push(2, 5, 0);
    open_pkt(2, 8'h50);
    open_pkt(7, 8'h50);
    repeat (3) @(negedge clk);
    chk(!gnt_o[2] && !gnt_o[7], "R5 waiters blocked", int'(gnt_o[2]) + int'(gnt_o[7]), 0);
    close_pkt(6);
    wait_evt(7);
    chk(!gnt_o[2], "R6 rotation order", int'(gnt_o[2]), 0);
    close_pkt(7);
    wait_evt(2);
    close_pkt(2);

    // R10: write in the lookup cycle is not seen by that header
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'h60; tbl_mask = 8'b0000_0001;
    push(0, 0, 1);
    open_pkt(0, 8'h60);
    @(negedge clk);
    tbl_we = 1'b0;
    wait_evt(0);
    close_pkt(0);
    push(0, 0, 0);
    open_pkt(0, 8'h60);
    wait_evt(0);
    close_pkt(0);

    // R11: waiting input picks up a member that comes up later
    link_up[6] = 1'b0;
    push(3, 7, 0);
    open_pkt(3, 8'h70);
    wait_evt(3);
    push(2, 6, 0);
    open_pkt(2, 8'h40);
    repeat (4) @(negedge clk);
    chk(!gnt_o[2] && !drop_o[2], "R11 still waiting", int'(gnt_o[2]) + int'(drop_o[2]), 0);
    link_up[6] = 1'b1;
    wait_evt(2);
    close_pkt(2);
    close_pkt(3);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected events seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule